// File: doc/BRIEF.md
# Framed Serial Control and Status Port

This block is a slave port for a synchronous serial link. A host pulls an active-low select line, clocks sixteen bits in and sixteen bits out with the least significant bit first, and then releases the select line. The bits that arrive become a control word. The control word drives six switch enables, an overcurrent-shutdown enable and a one-cycle status-clear strobe. The bits that leave form a status word, which is built from parallel status inputs.

The serial clock, select and data pins arrive without any relation to the system clock. Each is brought in through a two-flop synchronizer. Edges on the synchronized lines are then detected in the system clock domain. The status word is captured when the frame opens. Its bit 0 is on the data output before the first serial clock edge, so a host can read the prewarning flag and end the frame at once. A frame that ends after any count of falling serial clock edges other than sixteen changes nothing.

The data output is meant to feed a tri-state pad. The port gives the data bit and a separate output enable for that pad.

Top module: `serial_ctl_slave`

## Requirements
- R1: After reset the six switch enables are 0, the overcurrent-shutdown enable is 1, the clear strobe is 0 and the data output enable is 0.
- R2: The data output enable goes to 1 when the select line falls and returns to 0 within a few system cycles after the select line rises.
- R3: The status word is captured when the select line falls. Its bit map is: bit 0 prewarning, bits 1 to 6 the six switch states, bit 13 short detected, bit 14 open load, bit 15 supply fail, and all other bits 0. Bit 0 is on the data output before any serial clock edge.
- R4: The first rising serial clock edge of a frame keeps bit 0 on the output. Each later rising edge moves to the next status bit, so the host finds status bit k on the output at falling edge k+1.
- R5: The data input is sampled on each falling serial clock edge, least significant bit first. When exactly 16 bits have been received, the word takes effect on the rising edge of select: bits 1 to 6 drive switch enables 0 to 5, and bit 13 drives the overcurrent-shutdown enable.
- R6: The control outputs do not change while a frame is in progress.
- R7: A frame that ends after fewer or more than 16 falling serial clock edges, including a frame with none, leaves all control outputs unchanged.
- R8: If bit 0 of a committed word is 1, the clear strobe is high for exactly one system cycle and is not stored. Bits 7 to 12, 14 and 15 have no effect on any output.
- R9: Changes on the status inputs during a frame do not change the bits shifted out in that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from host |
| csn | input | 1 | Active-low frame select |
| sdi | input | 1 | Serial data from host |
| sdo | output | 1 | Serial status data to host |
| sdo_oe | output | 1 | Output enable for the sdo pad |
| prewarn | input | 1 | Temperature prewarning flag |
| sw_state | input | 6 | Actual switch states, LS1 HS1 LS2 HS2 LS3 HS3 from bit 0 |
| short_det | input | 1 | Short-circuit detected flag |
| open_load | input | 1 | Open-load flag |
| supply_fail | input | 1 | Supply-fail flag |
| srr_pulse | output | 1 | One-cycle status-clear strobe |
| sw_en | output | 6 | Switch enables, same order as sw_state |
| ocs_en | output | 1 | Overcurrent-shutdown enable |

## Verification
A bit counter that slips by one shows in two ways. A valid frame is dropped, which leaves the switch enables stale. A short frame is applied, which changes the enables as soon as select rises. Either error is visible at the ports within a few system cycles of the frame end. A transmit register that shifts on the wrong edge, or that is reloaded during the frame, corrupts the status bits the host reads during that same frame. A bad snapshot of the status inputs also shows up as wrong bits in that frame.

// File: rtl/serial_ctl_slave.sv
module serial_ctl_slave #(
  parameter int W = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sclk,
  input  logic       csn,
  input  logic       sdi,
  output logic       sdo,
  output logic       sdo_oe,
  input  logic       prewarn,
  input  logic [5:0] sw_state,
  input  logic       short_det,
  input  logic       open_load,
  input  logic       supply_fail,
  output logic       srr_pulse,
  output logic [5:0] sw_en,
  output logic       ocs_en
);
  localparam int CW = $clog2(W + 2);

  logic [2:0]    sclk_sr, csn_sr;
  logic [1:0]    sdi_sr;
  logic [W-1:0]  tx, rx;
  logic [CW-1:0] cnt;
  logic          active, first;

  wire sclk_rise = sclk_sr[1] & ~sclk_sr[2];
  wire sclk_fall = ~sclk_sr[1] & sclk_sr[2];
  wire cs_fall   = ~csn_sr[1] & csn_sr[2];
  wire cs_rise   = csn_sr[1] & ~csn_sr[2];
  wire commit    = cs_rise & active & (cnt == CW'(W));

  wire [W-1:0] status_word = W'({supply_fail, open_load, short_det, 6'b0, sw_state, prewarn});

  assign sdo    = tx[0];
  assign sdo_oe = active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_sr <= 3'b000;
      csn_sr  <= 3'b111;
      sdi_sr  <= 2'b00;
    end else begin
      sclk_sr <= {sclk_sr[1:0], sclk};
      csn_sr  <= {csn_sr[1:0], csn};
      sdi_sr  <= {sdi_sr[0], sdi};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      first  <= 1'b0;
      tx     <= '0;
      rx     <= '0;
      cnt    <= '0;
    end else if (cs_fall) begin
      active <= 1'b1;
      first  <= 1'b1;
      tx     <= status_word;
      rx     <= '0;
      cnt    <= '0;
    end else if (cs_rise) begin
      active <= 1'b0;
    end else if (active) begin
      if (sclk_rise) begin
        if (first) first <= 1'b0;
        else       tx    <= tx >> 1;
      end
      if (sclk_fall) begin
        rx <= {sdi_sr[1], rx[W-1:1]};
        if (cnt != CW'(W + 1)) cnt <= cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_en     <= '0;
      ocs_en    <= 1'b1;
      srr_pulse <= 1'b0;
    end else begin
      srr_pulse <= commit & rx[0];
      if (commit) begin
        sw_en  <= rx[6:1];
        ocs_en <= rx[13];
      end
    end
  end

  // R2
  oe_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (csn_sr[1] && csn_sr[2]) |=> !sdo_oe);

  // R6
  ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_rise |=> ($stable(sw_en) && $stable(ocs_en)));

  // R8
  srr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    srr_pulse |=> !srr_pulse);

  // R4
  sdo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !sclk_rise && !cs_fall) |=> $stable(sdo));

  // R7
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(W + 1));
endmodule

// File: tb/serial_ctl_slave_tb.sv
module serial_ctl_slave_tb;
  localparam int H = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0;
  logic csn = 1'b1;
  logic sdi = 1'b0;
  logic [15:0] stv = '0;
  logic sdo, sdo_oe, srr_pulse, ocs_en;
  logic [5:0] sw_en;

  int checks = 0;
  int errors = 0;
  int srr_cnt = 0;
  int mbits = 0;
  logic [15:0] mword = '0;
  logic [15:0] exp_q[$];
  logic [5:0] exp_sw;
  logic exp_ocs;

  always #4 clk = ~clk;

  serial_ctl_slave u_dut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .csn(csn), .sdi(sdi),
    .sdo(sdo), .sdo_oe(sdo_oe),
    .prewarn(stv[0]), .sw_state(stv[6:1]), .short_det(stv[13]),
    .open_load(stv[14]), .supply_fail(stv[15]),
    .srr_pulse(srr_pulse), .sw_en(sw_en), .ocs_en(ocs_en)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (srr_pulse) srr_cnt++;

  always @(negedge sclk) begin
    if (!csn) begin
      if (mbits < 16) mword[mbits] = sdo;
      mbits++;
    end
  end

  always @(posedge csn) begin
    if (mbits > 0 && exp_q.size() > 0) begin
      logic [15:0] e, m;
      e = exp_q.pop_front();
      m = (mbits >= 16) ? 16'hFFFF : 16'((1 << mbits) - 1);
      // R4 R9 status bit stream against snapshot
      chk("R4/R9 status stream", mword & m, e & m);
    end
    mbits = 0;
    mword = '0;
  end

  task automatic frame(input logic [15:0] w, input int nb,
                       input logic [15:0] st, input logic [15:0] st_mid);
    logic [5:0] pre_sw;
    logic pre_ocs;
    stv = st;
    repeat (2) @(negedge clk);
    csn = 1'b0;
    repeat (6) @(negedge clk);
    chk("R2 oe on", sdo_oe, 1'b1);
    chk("R3 bit0 before clock", sdo, st[0]);
    if (nb > 0) exp_q.push_back(st);
    pre_sw = sw_en;
    pre_ocs = ocs_en;
    for (int i = 0; i < nb; i++) begin
      sdi = (i < 16) ? w[i] : 1'b0;
      sclk = 1'b1;
      repeat (H) @(negedge clk);
      if (i == nb / 2) stv = st_mid;
      sclk = 1'b0;
      repeat (H) @(negedge clk);
      if (i == 7) chk("R6 mid-frame hold", {pre_ocs, pre_sw}, {ocs_en, sw_en});
    end
    csn = 1'b1;
    repeat (6) @(negedge clk);
    chk("R2 oe off", sdo_oe, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int s0;
    repeat (3) @(negedge clk);
    // R1
    chk("R1 sw_en reset", sw_en, 6'h00);
    chk("R1 ocs reset", ocs_en, 1'b1);
    chk("R1 srr reset", srr_pulse, 1'b0);
    chk("R1 oe reset", sdo_oe, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R5 plain frame
    frame(16'h2016, 16, 16'h805A, 16'h805A);
    chk("R5 sw_en", sw_en, 6'h0B);
    chk("R5 ocs", ocs_en, 1'b1);
    chk("R8 no strobe", srr_cnt, 0);

    // R5 R8 strobe on bit0
    frame(16'h0055, 16, 16'h6025, 16'h6025);
    chk("R5 sw_en", sw_en, 6'h2A);
    chk("R5 ocs off", ocs_en, 1'b0);
    chk("R8 one strobe", srr_cnt, 1);
    chk("R8 strobe not held", srr_pulse, 1'b0);

    // R7 short frame
    frame(16'hFFFF, 9, 16'h0001, 16'h0001);
    chk("R7 short sw", sw_en, 6'h2A);
    chk("R7 short ocs", ocs_en, 1'b0);

    // R7 long frame
    frame(16'h207E, 17, 16'h4040, 16'h4040);
    chk("R7 long sw", sw_en, 6'h2A);
    chk("R7 long ocs", ocs_en, 1'b0);

    // R3 R7 read-only abort
    frame(16'h0000, 0, 16'h0001, 16'h0001);
    chk("R7 abort sw", sw_en, 6'h2A);
    chk("R8 no strobe on abort", srr_cnt, 1);

    // R8 unused bits
    frame(16'hDF80, 16, 16'h0000, 16'h0000);
    chk("R8 unused sw", sw_en, 6'h00);
    chk("R8 unused ocs", ocs_en, 1'b0);
    chk("R8 unused no strobe", srr_cnt, 1);

    // R9 status change mid-frame
    frame(16'hFFFF, 16, 16'hA05B, 16'h4024);
    chk("R5 all ones sw", sw_en, 6'h3F);
    chk("R5 all ones ocs", ocs_en, 1'b1);
    chk("R8 all ones strobe", srr_cnt, 2);

    s0 = checks;
    repeat (4) @(negedge clk);
    chk("R9 queue drained", exp_q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule